// File: doc/BRIEF.md
# Fractional Power Gain Unit

This block produces the scale factor T^-c that a fractional differintegral filter multiplies its weighted sum by. It is given the fractional order c and a precomputed value of ln(T) and it forms the gain as exp(-c * ln T). It never uses a general power operator. Its exponential core only accepts arguments between -1 and +1. The product -c * ln T is therefore first scaled by one tenth, the exponential is taken of the reduced value, and the result is raised to the tenth power to restore the true gain.

The unit runs one computation at a time and shares a single fixed-point multiplier across all steps. A start strobe in the idle state latches both operands. The state machine then moves through these states:
- `ST_IDLE` goes to `ST_ARG` on start.
- `ST_ARG` forms and range-checks the reduced argument. It goes to `ST_FINISH` on a range error and to `ST_EXP_MUL` otherwise.
- `ST_EXP_MUL` and `ST_EXP_DIV` alternate once per Taylor term, evaluating the series by Horner's rule. `ST_EXP_DIV` goes back to `ST_EXP_MUL` while terms remain and to `ST_POW` after the last term.
- `ST_POW` runs the four-step chain y², y⁴, y⁸, y⁸·y², then goes to `ST_FINISH`.
- `ST_FINISH` registers the result, pulses done and returns to `ST_IDLE`.

A result too large for the output format is clamped and flagged. An argument outside the allowed magnitude is rejected with its own flag.

Top module: `frac_gain_unit`

## Requirements
- R1: After reset, gain_o, done_o, ovf_o and range_err_o are all 0.
- R2: done_o is high for exactly one cycle per accepted start. gain_o, ovf_o and range_err_o change only in that cycle and hold their values until the next result.
- R3: order_i and ln_step_i are two's complement, IN_W = 24 bits with IN_F = 17 fraction bits. gain_o is two's complement, OUT_W = 32 bits with OUT_F = 17 fraction bits. When no flag is set, gain_o equals exp(-c * lnT) of the latched operands within 0.5 % or 3 LSB, whichever is larger. Internally, the argument passed to the exponential core lies within ±1.
- R4: For an accepted argument, done_o rises 2*TERMS + 6 rising edges after the edge that samples start_i (26 with TERMS = 10).
- R5: If |c * lnT| > 10, done_o rises 2 edges after the sampling edge, with range_err_o = 1, gain_o = 0 and ovf_o = 0.
- R6: A magnitude of exactly 10 is accepted (range_err_o = 0).
- R7: If the gain exceeds the largest output value, gain_o = 2^(OUT_W-1) - 1 (0x7FFFFFFF) and ovf_o = 1.
- R8: start_i is ignored while a computation is in progress. The running result belongs to the first operands, and no extra done_o pulse follows.
- R9: gain_o is never negative, and ovf_o and range_err_o are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled in idle only |
| order_i | input | 24 | Fractional order c, signed Q6.17 |
| ln_step_i | input | 24 | Natural log of the sampling interval, signed Q6.17 |
| gain_o | output | 32 | Gain T^-c, signed Q14.17 |
| done_o | output | 1 | One-cycle result strobe |
| ovf_o | output | 1 | Gain saturated |
| range_err_o | output | 1 | Argument magnitude above 10 |

## Verification
The bench builds the unit with its default parameters: 24-bit Q17 inputs, a 48-bit Q28 working format, a 10-term series and a 32-bit Q17 output. With these values, the full argument span of ±10 maps to gains from about 4.5e-5 to 22026. Both ends of that span can therefore be reached directly, including the saturation point near 16384 and the exact boundary where the magnitude equals 10. Order values of 0.2 and -0.6 with a 0.5 ms interval check accuracy at the typical operating points. Order 0.99 exercises a large gain that still fits the output.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARG,
        ST_EXP_MUL,
        ST_EXP_DIV,
        ST_POW,
        ST_FINISH
    } fpg_state_e;

    // Reciprocal 1/k in a fixed-point format with frac fraction bits
    function automatic longint fpg_recip(input int k, input int frac);
        return (longint'(1) << frac) / longint'(k);
    endfunction

endpackage

// File: rtl/fpg_arg_stage.sv
module fpg_arg_stage #(
    parameter int IN_W    = 24,
    parameter int IN_F    = 17,
    parameter int WK_W    = 48,
    parameter int WK_F    = 28,
    parameter int ARG_LIM = 10
) (
    input  logic signed [IN_W-1:0] ord_i,
    input  logic signed [IN_W-1:0] lnt_i,
    output logic signed [WK_W-1:0] red_o,
    output logic                   range_err_o
);
    localparam int PW = 2*IN_W + 1;
    localparam int RS = WK_F + 12;
    localparam int SH = 2*IN_F + RS - WK_F;
    localparam int QW = PW + RS;
    localparam longint TENTH = (longint'(1) << RS) / 10;
    localparam logic signed [QW-1:0] TENTH_Q = QW'(TENTH);
    localparam logic signed [PW-1:0] LIM = PW'(longint'(ARG_LIM) << (2*IN_F));

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] neg;
    logic signed [PW-1:0] mag;
    logic signed [QW-1:0] scaled;

    always_comb begin
        prod   = PW'(ord_i) * PW'(lnt_i);
        neg    = -prod;
        mag    = neg[PW-1] ? -neg : neg;
        range_err_o = (mag > LIM);
        scaled = QW'(neg) * TENTH_Q;
        red_o  = WK_W'(scaled >>> SH);
    end

endmodule

// File: rtl/fpg_fxmul.sv
module fpg_fxmul #(
    parameter int W = 48,
    parameter int F = 28
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] p_o
);
    localparam int PW = 2*W;

    logic signed [PW-1:0] full;

    always_comb begin
        full = PW'(a_i) * PW'(b_i);
        p_o  = W'(full >>> F);
    end

endmodule

// File: rtl/fpg_out_sat.sv
module fpg_out_sat #(
    parameter int WK_W  = 48,
    parameter int WK_F  = 28,
    parameter int OUT_W = 32,
    parameter int OUT_F = 17
) (
    input  logic signed [WK_W-1:0]  val_i,
    output logic signed [OUT_W-1:0] gain_o,
    output logic                    ovf_o
);
    localparam int DS = WK_F - OUT_F;
    localparam logic signed [OUT_W-1:0] OMAX = {1'b0, {(OUT_W-1){1'b1}}};

    logic signed [WK_W-1:0] shifted;

    always_comb begin
        shifted = val_i >>> DS;
        ovf_o   = 1'b0;
        if (shifted > WK_W'(OMAX)) begin
            gain_o = OMAX;
            ovf_o  = 1'b1;
        end else if (shifted < 0) begin
            gain_o = '0;
        end else begin
            gain_o = OUT_W'(shifted);
        end
    end

endmodule

// File: rtl/frac_gain_unit.sv
module frac_gain_unit
    import fpg_pkg::*;
#(
    parameter int IN_W    = 24,
    parameter int IN_F    = 17,
    parameter int WK_W    = 48,
    parameter int WK_F    = 28,
    parameter int OUT_W   = 32,
    parameter int OUT_F   = 17,
    parameter int TERMS   = 10,
    parameter int ARG_LIM = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [IN_W-1:0]  order_i,
    input  logic [IN_W-1:0]  ln_step_i,
    output logic [OUT_W-1:0] gain_o,
    output logic             done_o,
    output logic             ovf_o,
    output logic             range_err_o
);
    localparam int KW = $clog2(TERMS + 1);
    localparam logic signed [WK_W-1:0] ONE = WK_W'(longint'(1) << WK_F);
    localparam logic [OUT_W-1:0] GMAX = {1'b0, {(OUT_W-1){1'b1}}};

    fpg_state_e state_q, state_d;

    logic signed [IN_W-1:0] ord_q, lnt_q;
    logic signed [WK_W-1:0] x_q, acc_q, y2_q;
    logic [KW-1:0]          k_q;
    logic [1:0]             pw_q;
    logic                   err_q;

    logic signed [WK_W-1:0] red;
    logic                   arg_err;
    logic signed [WK_W-1:0] op_b, mul_p;
    logic signed [OUT_W-1:0] sat_gain;
    logic                   sat_ovf;
    logic signed [WK_W-1:0] recip_tab [0:TERMS];

    // Constant reciprocal table 1/k for the Horner steps
    for (genvar g = 0; g <= TERMS; g++) begin : g_recip
        if (g == 0) begin : g_zero
            assign recip_tab[g] = '0;
        end else begin : g_val
            localparam longint RV = fpg_recip(g, WK_F);
            assign recip_tab[g] = WK_W'(RV);
        end
    end

    fpg_arg_stage #(
        .IN_W(IN_W), .IN_F(IN_F), .WK_W(WK_W), .WK_F(WK_F), .ARG_LIM(ARG_LIM)
    ) u_arg (
        .ord_i(ord_q),
        .lnt_i(lnt_q),
        .red_o(red),
        .range_err_o(arg_err)
    );

    // Shared multiplier: operand B picked by state
    always_comb begin
        unique case (state_q)
            ST_EXP_MUL: op_b = x_q;
            ST_EXP_DIV: op_b = recip_tab[k_q];
            ST_POW:     op_b = (pw_q == 2'd3) ? y2_q : acc_q;
            default:    op_b = acc_q;
        endcase
    end

    fpg_fxmul #(.W(WK_W), .F(WK_F)) u_mul (
        .a_i(acc_q),
        .b_i(op_b),
        .p_o(mul_p)
    );

    fpg_out_sat #(
        .WK_W(WK_W), .WK_F(WK_F), .OUT_W(OUT_W), .OUT_F(OUT_F)
    ) u_sat (
        .val_i(acc_q),
        .gain_o(sat_gain),
        .ovf_o(sat_ovf)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ARG;
            ST_ARG:     state_d = arg_err ? ST_FINISH : ST_EXP_MUL;
            ST_EXP_MUL: state_d = ST_EXP_DIV;
            ST_EXP_DIV: state_d = (k_q == KW'(1)) ? ST_POW : ST_EXP_MUL;
            ST_POW:     if (pw_q == 2'd3) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ord_q <= '0;
            lnt_q <= '0;
            x_q   <= '0;
            acc_q <= '0;
            y2_q  <= '0;
            k_q   <= '0;
            pw_q  <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ord_q <= order_i;
                        lnt_q <= ln_step_i;
                    end
                end
                ST_ARG: begin
                    err_q <= arg_err;
                    x_q   <= red;
                    acc_q <= ONE;
                    k_q   <= KW'(TERMS);
                end
                ST_EXP_MUL: acc_q <= mul_p;
                ST_EXP_DIV: begin
                    acc_q <= ONE + mul_p;
                    k_q   <= k_q - KW'(1);
                    pw_q  <= 2'd0;
                end
                ST_POW: begin
                    acc_q <= mul_p;
                    if (pw_q == 2'd0) y2_q <= mul_p;
                    pw_q  <= pw_q + 2'd1;
                end
                default: ;
            endcase
        end
    end

    // Output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gain_o      <= '0;
            done_o      <= 1'b0;
            ovf_o       <= 1'b0;
            range_err_o <= 1'b0;
        end else begin
            done_o <= (state_q == ST_FINISH);
            if (state_q == ST_FINISH) begin
                gain_o      <= err_q ? '0 : OUT_W'(sat_gain);
                ovf_o       <= !err_q && sat_ovf;
                range_err_o <= err_q;
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R3
    core_arg_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ARG && !arg_err) |-> (red <= ONE && red >= -ONE));

    // R5
    err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        range_err_o |-> (gain_o == '0 && !ovf_o));

    // R7
    sat_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (gain_o == GMAX));

    // R8
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE) |=> ($stable(ord_q) && $stable(lnt_q)));

    // R9
    gain_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gain_o[OUT_W-1] && !(ovf_o && range_err_o));

endmodule

// File: tb/frac_gain_unit_tb.sv
module frac_gain_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TERMS = 10;
    localparam int LAT_OK = 2*TERMS + 6;
    localparam int LAT_ERR = 2;
    localparam real SCALE = 131072.0;
    localparam longint GMAX = 64'h7FFFFFFF;

    typedef struct packed {
        logic signed [23:0] c;
        logic signed [23:0] l;
        logic               e_err;
        logic               e_ovf;
    } vec_t;

    // c and lnT in Q17; lnT = -996265 is ln(0.5 ms)
    localparam vec_t VECS [10] = '{
        '{ 24'sd26214,   -24'sd996265, 1'b0, 1'b0},  // c=0.2, ~4.57
        '{-24'sd78643,   -24'sd996265, 1'b0, 1'b0},  // c=-0.6, ~0.0105
        '{ 24'sd129761,  -24'sd996265, 1'b0, 1'b0},  // c=0.99, ~1850
        '{ 24'sd0,       -24'sd996265, 1'b0, 1'b0},  // gain 1
        '{ 24'sd170394,  -24'sd996265, 1'b0, 1'b1},  // 9.88 -> saturate
        '{ 24'sd183501,  -24'sd996265, 1'b1, 1'b0},  // 10.64 -> range error
        '{ 24'sd1310720, -24'sd131072, 1'b0, 1'b1},  // exactly 10
        '{ 24'sd1310721, -24'sd131072, 1'b1, 1'b0},  // just above 10
        '{-24'sd1310720, -24'sd131072, 1'b0, 1'b0},  // exactly -10
        '{-24'sd26214,    24'sd131072, 1'b0, 1'b0}   // exp(0.2)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] order = '0;
    logic [23:0] lnstep = '0;
    logic [31:0] gain;
    logic        done, ovf, rerr;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_gain_unit u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .order_i(order), .ln_step_i(lnstep),
        .gain_o(gain), .done_o(done), .ovf_o(ovf), .range_err_o(rerr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_op(input logic signed [23:0] c, input logic signed [23:0] l, output int lat);
        @(negedge clk);
        order = c; lnstep = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 500) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic longint expect_lsb(input logic signed [23:0] c, input logic signed [23:0] l);
        real cr, lr;
        cr = real'(c) / SCALE;
        lr = real'(l) / SCALE;
        return longint'($rtoi($exp(-cr * lr) * SCALE + 0.5));
    endfunction

    task automatic chk_gain(input string req, input longint exp);
        real tol;
        longint diff;
        tol = 0.005 * real'(exp);
        if (tol < 3.0) tol = 3.0;
        diff = longint'(gain) - exp;
        if (diff < 0) diff = -diff;
        chk(real'(diff) <= tol, req, longint'(gain), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int lat;
        longint g0;
        int extra;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(gain == 0, "R1 gain", longint'(gain), 0);
        chk(done == 0, "R1 done", longint'(done), 0);
        chk(ovf == 0,  "R1 ovf", longint'(ovf), 0);
        chk(rerr == 0, "R1 range_err", longint'(rerr), 0);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            do_op(VECS[i].c, VECS[i].l, lat);
            // R4 / R5 latency
            if (VECS[i].e_err)
                chk(lat == LAT_ERR, "R5 latency", lat, LAT_ERR);
            else
                chk(lat == LAT_OK, "R4 latency", lat, LAT_OK);
            // R5, R6 range flag
            chk(rerr == VECS[i].e_err, "R5/R6 range_err", longint'(rerr), longint'(VECS[i].e_err));
            // R7 overflow flag
            chk(ovf == VECS[i].e_ovf, "R7 ovf", longint'(ovf), longint'(VECS[i].e_ovf));
            if (VECS[i].e_err)
                chk(gain == 0, "R5 gain zero", longint'(gain), 0);
            else if (VECS[i].e_ovf)
                chk(longint'(gain) == GMAX, "R7 saturated gain", longint'(gain), GMAX);
            else
                chk_gain("R3 gain", expect_lsb(VECS[i].c, VECS[i].l));
            // R9 sign and flag exclusion
            chk(!gain[31] && !(ovf && rerr), "R9 sign/flags", longint'({ovf, rerr}), 0);
            g0 = longint'(gain);
            @(negedge clk);
            // R2 single-cycle done
            chk(done == 0, "R2 done pulse", longint'(done), 0);
            repeat (3) @(negedge clk);
            chk(longint'(gain) == g0, "R2 hold", longint'(gain), g0);
        end

        // R8 start while busy is ignored
        @(negedge clk);
        order = 24'sd26214; lnstep = -24'sd996265; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 500) begin
            @(negedge clk);
            lat++;
            if (lat == 5) begin
                order = -24'sd78643; start = 1'b1;
            end else if (lat == 6) begin
                start = 1'b0;
            end
        end
        chk(lat == LAT_OK, "R8 latency", lat, LAT_OK);
        chk_gain("R8 first operands", expect_lsb(24'sd26214, -24'sd996265));
        extra = 0;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R8 no extra done", extra, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule